// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a single-clock static memory with a registered command stage and a registered read port. A read command returns its word one clock later. A write command supplies its address on one edge and its data on the next edge. Because write data arrives late, a bus that carries read results can be handed to write data without an idle slot. Each 9-bit lane has its own active-low write select. A write whose data has been captured stays in a holding register. It is committed to the array only when the next write's data is captured. Until then, reads of that address take the enabled lanes from the holding register.

The data bus is modelled as separate input, output and drive-enable signals. The drive enable is switched off during a write's data cycle, after a deselect, while sleeping, and whenever the asynchronous output enable is high. A sleep input halts all accesses two clocks after it rises and releases them two clocks after it falls. Memory contents and the held write are kept while asleep. The block has fixed timing and no back-pressure: every accepted command completes on schedule, so none of its ports use a valid/ready handshake.

Top module: `lw_sram`

## Requirements
- R1: A read (ce_n low, we_n high at edge k) loads the addressed word into d_out at edge k+1. d_oe is then high during the following cycle, provided oe_n is low and no write is accepted at edge k+1.
- R2: A write (ce_n low, we_n low at edge k) takes addr at edge k and d_in at edge k+1. Lane i is bits [9i+8:9i]. Once committed, the word is read back from the array.
- R3: bwe_n[i] low enables lane i. Lanes with bwe_n high keep their contents. With bwe_n all ones the write changes nothing.
- R4: A read of the address held in the pending write register takes each enabled lane from that register and every other lane from the array.
- R5: Successive writes retire in issue order, one per cycle. For repeated writes to one address, the later write wins lane by lane. The pending write is held unchanged until the next write's data is captured.
- R6: d_oe is low during the cycle that follows a write's address edge (its data cycle), whatever oe_n is.
- R7: With ce_n high at edge k, d_oe is low for the cycle after edge k+1.
- R8: oe_n acts asynchronously. While it is high, d_oe is low within the same cycle, and d_out keeps its value.
- R9: A synchronous active-high rst leaves the block deselected, with d_oe low and d_out zero.
- R10: Two edges after sleep is seen high, commands are ignored and d_oe is low. Two edges after it is seen low, commands are accepted again. Array words and the pending write are kept across sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Low selects write, high selects read |
| bwe_n | input | BYTES | Per-lane write selects, active low |
| addr | input | ADDR_W | Word address |
| d_in | input | BYTES*BYTE_W | Write data, sampled one edge after the address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power request, active high |
| d_out | output | BYTES*BYTE_W | Registered read data |
| d_oe | output | 1 | Bus drive enable |

## Verification
The bench uses the default build: 256 words, four lanes of 9 bits and a two-stage sleep delay. With a 256-word array, each address can be tracked individually in a scoreboard model. The 9-bit lanes put the top bit of every lane inside the masking and forwarding checks. The four write selects allow full, partial and aborted writes, and partial bypass reads, to be produced from a short directed sequence. The two-edge sleep delay is short enough to place ignored writes and reads inside one sleep window and then read the kept data back.

// File: rtl/lw_sram_pkg.sv
`timescale 1ns/1ps
package lw_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } lw_op_e;
endpackage

// File: rtl/lw_sleep_sync.sv
`timescale 1ns/1ps
module lw_sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_in,
  output logic asleep
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], sleep_in};
  end

  assign asleep = chain_q[STAGES-1];
endmodule

// File: rtl/lw_cmd_stage.sv
`timescale 1ns/1ps
module lw_cmd_stage
  import lw_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          asleep,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [NB-1:0] bwe_n,
  output lw_op_e        op_q,
  output logic [AW-1:0] addr_q,
  output logic [NB-1:0] be_q
);
  lw_op_e op_d;

  always_comb begin
    if (asleep || ce_n) op_d = OP_IDLE;
    else if (we_n)      op_d = OP_READ;
    else                op_d = OP_WRITE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      be_q   <= '0;
    end else begin
      op_q <= op_d;
      if (op_d != OP_IDLE) begin
        addr_q <= addr;
        be_q   <= (op_d == OP_WRITE) ? ~bwe_n : '0;
      end
    end
  end
endmodule

// File: rtl/lw_array.sv
`timescale 1ns/1ps
module lw_array #(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [NB-1:0]    wr_be,
  input  logic [NB*BW-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [NB*BW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BW-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[g]) bank[wr_addr] <= wr_data[g*BW +: BW];
    end

    assign rd_data[g*BW +: BW] = bank[rd_addr];
  end
endmodule

// File: rtl/lw_write_buffer.sv
`timescale 1ns/1ps
module lw_write_buffer #(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic [AW-1:0]    cap_addr,
  input  logic [NB-1:0]    cap_be,
  input  logic [NB*BW-1:0] cap_data,
  input  logic [AW-1:0]    rd_addr,
  input  logic [NB*BW-1:0] arr_word,
  output logic [NB*BW-1:0] fwd_word,
  output logic             cm_en,
  output logic [AW-1:0]    cm_addr,
  output logic [NB-1:0]    cm_be,
  output logic [NB*BW-1:0] cm_data
);
  logic [AW-1:0]    pend_addr;
  logic [NB-1:0]    pend_be;
  logic [NB*BW-1:0] pend_data;
  logic             hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_addr <= '0;
      pend_be   <= '0;
      pend_data <= '0;
    end else if (cap_en) begin
      pend_addr <= cap_addr;
      pend_be   <= cap_be;
      pend_data <= cap_data;
    end
  end

  // The older pending write retires on the edge that captures the new one.
  assign cm_en   = cap_en;
  assign cm_addr = pend_addr;
  assign cm_be   = pend_be;
  assign cm_data = pend_data;

  assign hit = (pend_addr == rd_addr);

  for (genvar g = 0; g < NB; g++) begin : g_fwd
    assign fwd_word[g*BW +: BW] = (hit && pend_be[g]) ? pend_data[g*BW +: BW]
                                                      : arr_word[g*BW +: BW];
  end

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> ($stable(pend_addr) && $stable(pend_be) && $stable(pend_data))); // R5
endmodule

// File: rtl/lw_out_stage.sv
`timescale 1ns/1ps
module lw_out_stage #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [DW-1:0] load_data,
  input  logic          wr_mask,
  input  logic          asleep,
  input  logic          oe_n,
  output logic [DW-1:0] d_out,
  output logic          d_oe
);
  logic drv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      d_out <= '0;
      drv_q <= 1'b0;
    end else begin
      drv_q <= load_en;
      if (load_en) d_out <= load_data;
    end
  end

  assign d_oe = drv_q & ~wr_mask & ~asleep & ~oe_n;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(d_out)); // R8
endmodule

// File: rtl/lw_sram.sv
`timescale 1ns/1ps
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BYTES     = 4,
  parameter int BYTE_W    = 9,
  parameter int SLEEP_LAT = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce_n,
  input  logic                    we_n,
  input  logic [BYTES-1:0]        bwe_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*BYTE_W-1:0] d_in,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [BYTES*BYTE_W-1:0] d_out,
  output logic                    d_oe
);
  localparam int DW = BYTES * BYTE_W;

  logic              asleep;
  lw_op_e            op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTES-1:0]  be_q;
  logic              cap_en;
  logic              rd_load;
  logic              wr_mask;
  logic [DW-1:0]     arr_word;
  logic [DW-1:0]     fwd_word;
  logic              cm_en;
  logic [ADDR_W-1:0] cm_addr;
  logic [BYTES-1:0]  cm_be;
  logic [DW-1:0]     cm_data;

  lw_sleep_sync #(.STAGES(SLEEP_LAT)) u_sleep (
    .clk(clk), .rst(rst), .sleep_in(sleep), .asleep(asleep)
  );

  lw_cmd_stage #(.AW(ADDR_W), .NB(BYTES)) u_cmd (
    .clk(clk), .rst(rst), .asleep(asleep), .ce_n(ce_n), .we_n(we_n),
    .addr(addr), .bwe_n(bwe_n), .op_q(op_q), .addr_q(addr_q), .be_q(be_q)
  );

  assign cap_en  = (op_q == OP_WRITE) && !asleep;
  assign rd_load = (op_q == OP_READ) && !asleep;
  assign wr_mask = (op_q == OP_WRITE);

  lw_write_buffer #(.AW(ADDR_W), .NB(BYTES), .BW(BYTE_W)) u_wbuf (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_addr(addr_q), .cap_be(be_q),
    .cap_data(d_in), .rd_addr(addr_q), .arr_word(arr_word), .fwd_word(fwd_word),
    .cm_en(cm_en), .cm_addr(cm_addr), .cm_be(cm_be), .cm_data(cm_data)
  );

  lw_array #(.AW(ADDR_W), .NB(BYTES), .BW(BYTE_W)) u_array (
    .clk(clk), .wr_en(cm_en), .wr_addr(cm_addr), .wr_be(cm_be),
    .wr_data(cm_data), .rd_addr(addr_q), .rd_data(arr_word)
  );

  lw_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .load_en(rd_load), .load_data(fwd_word),
    .wr_mask(wr_mask), .asleep(asleep), .oe_n(oe_n), .d_out(d_out), .d_oe(d_oe)
  );

  AST_WRITE_DATA_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(!ce_n && !we_n && !asleep) |-> !d_oe); // R6

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(ce_n, 2) |-> !d_oe); // R7

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(sleep, 2) |-> !d_oe); // R10
endmodule

// File: tb/lw_sram_tb_top.sv
`timescale 1ns/1ps
module lw_sram_tb_top;
  localparam int AW = 8;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int DW = NB * BW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1;
  logic          we_n = 1'b1;
  logic          oe_n = 1'b0;
  logic          sleep = 1'b0;
  logic [NB-1:0] bwe_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] d_out;
  logic          d_oe;

  always #2 clk = ~clk;

  lw_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW), .SLEEP_LAT(2)) dut_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .bwe_n(bwe_n), .addr(addr),
    .d_in(d_in), .oe_n(oe_n), .sleep(sleep), .d_out(d_out), .d_oe(d_oe)
  );

  typedef struct {
    int            cyc;
    bit            oe;
    bit            chk_data;
    logic [DW-1:0] data;
    string         req;
  } item_t;

  item_t         sbq[$];
  int            checks = 0;
  int            errors = 0;
  int            cyc = 0;
  logic [DW-1:0] gold [256];
  bit            sl_at [8192];
  bit            prev_rd = 0;
  int            prev_kind = 0;
  logic [DW-1:0] prev_data = '0;
  string         prev_tag = "R1";
  logic [DW-1:0] late_data = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (edge %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] mask_of(input logic [NB-1:0] ben);
    logic [DW-1:0] m = '0;
    for (int i = 0; i < NB; i++) if (!ben[i]) m[i*BW +: BW] = '1;
    return m;
  endfunction

  // kind: 0 idle, 1 read, 2 write
  task automatic issue(input int kind, input logic [AW-1:0] a, input logic [NB-1:0] ben,
                       input logic [DW-1:0] wd, input bit oe, input bit slp, input string tag);
    int    e;
    bit    acc;
    bit    wmask;
    item_t it;
    @(negedge clk);
    e = cyc + 1;
    ce_n  = (kind == 0);
    we_n  = (kind != 2);
    addr  = a;
    bwe_n = ben;
    oe_n  = oe;
    sleep = slp;
    d_in  = late_data;
    sl_at[e] = slp;
    acc   = !sl_at[e-2];
    wmask = (kind == 2) && acc;
    it.cyc = e;
    it.oe  = prev_rd && !sl_at[e-2] && !wmask && !oe && !sl_at[e-1];
    it.chk_data = it.oe;
    it.data = prev_data;
    if (wmask && prev_rd)             it.req = "R6";
    else if (sl_at[e-1] || sl_at[e-2]) it.req = "R10";
    else if (prev_kind == 0)          it.req = "R7";
    else if (oe && prev_rd)           it.req = "R8";
    else if (prev_rd)                 it.req = prev_tag;
    else                              it.req = "R1";
    sbq.push_back(it);
    prev_rd   = (kind == 1) && acc;
    prev_kind = kind;
    if (kind == 1 && acc) begin
      prev_data = gold[a];
      prev_tag  = tag;
    end
    if (kind == 2 && acc) gold[a] = (gold[a] & ~mask_of(ben)) | (wd & mask_of(ben));
    late_data = (kind == 2) ? wd : ~wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(0, '0, '1, '0, 1'b0, 1'b0, "R7");
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [NB-1:0] ben, input logic [DW-1:0] wd);
    issue(2, a, ben, wd, 1'b0, 1'b0, "R2");
  endtask
  task automatic rd(input logic [AW-1:0] a, input string tag);
    issue(1, a, '1, '0, 1'b0, 1'b0, tag);
  endtask

  // Monitor: compare each window against the scoreboard
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      cyc++;
      #1;
      while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
        it = sbq.pop_front();
        if (it.cyc == cyc) begin
          check(d_oe === it.oe, it.req, "drive", DW'(d_oe), DW'(it.oe));
          if (it.chk_data) check(d_out === it.data, it.req, "data", d_out, it.data);
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) gold[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check(d_oe === 1'b0, "R9", "reset drive", DW'(d_oe), '0);
    check(d_out === '0, "R9", "reset data", d_out, '0);
    @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R4 full bypass from the pending write
    wr(8'd10, 4'b0000, 36'hA_BCDE_F012);
    rd(8'd10, "R4");
    idle(1);

    // R5 ordered retirement of back-to-back writes
    wr(8'd20, 4'b0000, 36'h1_1111_1111);
    wr(8'd21, 4'b0000, 36'h2_2222_2222);
    wr(8'd22, 4'b0000, 36'h3_3333_3333);
    idle(1);
    rd(8'd20, "R5");
    rd(8'd21, "R5");
    rd(8'd22, "R4");
    rd(8'd10, "R2");
    idle(1);

    // R3 partial write, lanes 0 and 2 enabled, partial bypass then array path
    wr(8'd20, 4'b1010, 36'hF_0F0F_0F0F);
    rd(8'd20, "R4");
    wr(8'd30, 4'b0110, 36'h5_A5A5_A5A5);
    rd(8'd20, "R3");
    idle(1);

    // R3 aborted write
    wr(8'd21, 4'b1111, 36'hD_EAD0_BEEF);
    rd(8'd21, "R3");
    wr(8'd40, 4'b0000, 36'h4_0404_0404);
    rd(8'd21, "R3");
    idle(1);

    // R5 same address twice, later lanes win
    wr(8'd50, 4'b0000, 36'h8_7654_3210);
    wr(8'd50, 4'b1100, 36'h0_0000_1FFF);
    rd(8'd50, "R5");
    idle(1);

    // R6 read followed at once by a write: data cycle masks drive
    rd(8'd10, "R1");
    wr(8'd60, 4'b0000, 36'h6_6006_6006);
    idle(1);
    rd(8'd60, "R1");
    rd(8'd30, "R1");
    rd(8'd40, "R1");
    idle(2);

    // R8 output enable high over a read result
    rd(8'd10, "R1");
    issue(0, '0, '1, '0, 1'b1, 1'b0, "R8");
    idle(1);

    // R8 asynchronous gate within one cycle
    rd(8'd20, "R1");
    idle(1);
    @(posedge clk);
    #1.5;
    oe_n = 1'b1;
    #0.2;
    check(d_oe === 1'b0, "R8", "async gate off", DW'(d_oe), '0);
    oe_n = 1'b0;
    #0.1;
    check(d_oe === 1'b1, "R8", "async gate on", DW'(d_oe), DW'(1));
    check(d_out === gold[20], "R8", "data held", d_out, gold[20]);
    idle(1);

    // R10 sleep: commands ignored, contents kept
    wr(8'd70, 4'b0000, 36'h7_7777_0007);
    idle(1);
    issue(0, '0, '1, '0, 1'b0, 1'b1, "R10");
    issue(0, '0, '1, '0, 1'b0, 1'b1, "R10");
    issue(2, 8'd70, 4'b0000, 36'h0_BAD0_BAD0, 1'b0, 1'b1, "R10");
    issue(1, 8'd70, '1, '0, 1'b0, 1'b1, "R10");
    issue(2, 8'd10, 4'b0000, 36'h0_BAD1_BAD1, 1'b0, 1'b1, "R10");
    issue(0, '0, '1, '0, 1'b0, 1'b0, "R10");
    idle(3);
    rd(8'd70, "R10");
    rd(8'd10, "R10");
    idle(3);

    wait (sbq.size() == 0);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule